// File: doc/BRIEF.md
# Square-Wave and Interrupt Output Controller

This block owns the configuration byte and the status byte of a timekeeping device and drives one shared output pin. A free-running edge counter advanced by every transition of the 32.768 kHz reference produces four square-wave rates with even duty. One configuration bit decides whether the pin carries the selected square wave or an active-low alarm interrupt. The status byte keeps two alarm flags and a sticky oscillator-stopped flag. Software can only clear these flags.

The reference clock reaches the block as `oscEdge`, which is a one-cycle pulse in the `clk` domain for each edge (rising or falling) of the 32.768 kHz signal. Register accesses are synchronous to `clk`. Reads are combinational on `regAddr`. The pin is modelled as a level plus an output enable, and a low enable means the pin floats.

Top module: `sqwIntCtrl`

## Requirements
- R1: After reset the configuration byte (address 0x0E) reads 0x18 and the status byte (address 0x0F) reads 0x80. The edge counter starts at 0.
- R2: The configuration byte has this layout: bit7 stop oscillator, bit6 reads 0, bit5 battery output enable, bit4:3 rate select, bit2 interrupt mode, bit1 alarm-2 enable, bit0 alarm-1 enable. Any address other than 0x0E and 0x0F reads 0.
- R3: A 16-bit edge counter adds one on each `oscEdge` while the oscillator runs. With interrupt mode 0 the pin level is one counter bit, chosen by the rate select. Rate 00 uses bit 15 (1 Hz), rate 01 uses bit 3 (4.096 kHz), rate 10 uses bit 2 (8.192 kHz) and rate 11 uses bit 0 (32.768 kHz).
- R4: While the stop bit is 1 the counter holds its value and `oscEdge` is ignored. If interrupt mode is also 0, `pinOe` is 0.
- R5: The oscillator-stopped flag is status bit 7. It is set by reset, by an `oscFault` pulse, and by a write that changes the stop bit from 0 to 1. Writing 0 to it clears it and writing 1 leaves it unchanged. A set event in the same cycle as a clear wins.
- R6: `alarmHit[0]` sets status bit 0 and `alarmHit[1]` sets status bit 1. Writing 0 to a flag bit clears that flag and writing 1 leaves it unchanged. A hit in the same cycle as a clear wins. Status bits 6:2 read 0.
- R7: With interrupt mode 1 the pin level is 0 while (bit0 flag AND alarm-1 enable) OR (bit1 flag AND alarm-2 enable) holds. Otherwise the pin level is 1.
- R8: `pinOe` is 0 while `battMode` is 1 and the battery output enable is 0. When neither this condition nor R4 applies, `pinOe` is 1.
- R9: Whenever `pinOe` is 0, `pinLevel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rstN | input | 1 | asynchronous active-low reset (power-on) |
| oscEdge | input | 1 | one pulse per 32.768 kHz reference edge |
| regWrEn | input | 1 | register write strobe |
| regAddr | input | 8 | register address |
| regWrData | input | 8 | register write data |
| regRdData | output | 8 | register read data for `regAddr` |
| alarmHit | input | 2 | alarm match pulses, bit0 alarm 1, bit1 alarm 2 |
| battMode | input | 1 | device is running from backup supply |
| oscFault | input | 1 | pulse reporting an oscillator failure |
| pinLevel | output | 1 | shared pin level |
| pinOe | output | 1 | shared pin output enable |

## Verification
The assertions assume that every input is synchronous to `clk` and that the write strobe, address and data stay valid for the whole cycle. They also assume that `alarmHit` and `oscFault` are one-cycle pulses that can arrive in any cycle, including the cycle of a status write. The stimulus changes inputs only just after a rising edge and holds them for whole cycles. It deliberately places alarm hits and fault pulses on the same cycle as clearing writes. It also runs `oscEdge` both steadily and in irregular patterns, so the counter-hold and flag-priority properties are exercised at their boundaries.

// File: rtl/sqwPkg.sv
package sqwPkg;
  typedef struct packed {
    logic       oscRun;
    logic [1:0] rateSel;
    logic       intMode;
    logic       irq;
    logic       pinAllow;
  } dpStrobes_t;
endpackage

// File: rtl/sqwControl.sv
module sqwControl
  import sqwPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [1:0]        alarmHit,
  input  logic              battMode,
  input  logic              oscFault,
  output dpStrobes_t        strb
);
  logic       stopOsc, battOut, intMode, a2En, a1En;
  logic [1:0] rateSel;
  logic       oscStopFlag;
  logic [1:0] alarmFlag;

  logic wrCtrl, wrStat, stopEvt;
  logic unusedWr;

  assign wrCtrl   = regWrEn && (regAddr == CTRL_ADDR);
  assign wrStat   = regWrEn && (regAddr == STAT_ADDR);
  assign stopEvt  = wrCtrl && regWrData[7] && !stopOsc;
  assign unusedWr = regWrData[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopOsc <= 1'b0;
      battOut <= 1'b0;
      rateSel <= 2'b11;
      intMode <= 1'b0;
      a2En    <= 1'b0;
      a1En    <= 1'b0;
    end else if (wrCtrl) begin
      stopOsc <= regWrData[7];
      battOut <= regWrData[5];
      rateSel <= regWrData[4:3];
      intMode <= regWrData[2];
      a2En    <= regWrData[1];
      a1En    <= regWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscStopFlag <= 1'b1;
    end else if (oscFault || stopEvt) begin
      oscStopFlag <= 1'b1;
    end else if (wrStat && !regWrData[7]) begin
      oscStopFlag <= 1'b0;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmFlag[i] <= 1'b0;
      end else if (alarmHit[i]) begin
        alarmFlag[i] <= 1'b1;
      end else if (wrStat && !regWrData[i]) begin
        alarmFlag[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = 8'h00;
    if (regAddr == CTRL_ADDR) begin
      regRdData = {stopOsc, 1'b0, battOut, rateSel, intMode, a2En, a1En};
    end else if (regAddr == STAT_ADDR) begin
      regRdData = {oscStopFlag, 5'b00000, alarmFlag};
    end
  end

  always_comb begin
    strb.oscRun   = !stopOsc;
    strb.rateSel  = rateSel;
    strb.intMode  = intMode;
    strb.irq      = (alarmFlag[0] && a1En) || (alarmFlag[1] && a2En);
    strb.pinAllow = !battMode || battOut;
  end

  // R5
  osf_write_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStat && !oscStopFlag && !oscFault |=> !oscStopFlag);
  // R5
  osf_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscFault |=> oscStopFlag);
  // R6
  a1_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit[0] |=> alarmFlag[0]);
  // R6
  a1_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStat && !regWrData[0] && !alarmHit[0] |=> !alarmFlag[0]);
  // R6
  a2_write_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStat && regWrData[1] && !alarmFlag[1] && !alarmHit[1] |=> !alarmFlag[1]);
endmodule

// File: rtl/sqwDatapath.sv
module sqwDatapath
  import sqwPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TAP_FAST = 0,
  parameter int TAP_HIGH = 2,
  parameter int TAP_MID  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEdge,
  input  dpStrobes_t strb,
  output logic       pinLevel,
  output logic       pinOe
);
  localparam int TAP_SLOW = CNT_W - 1;

  logic [CNT_W-1:0] edgeCnt;
  logic             wave;
  logic             unusedCnt;

  assign unusedCnt = ^edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (strb.oscRun && oscEdge) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (strb.rateSel)
      2'b00:   wave = edgeCnt[TAP_SLOW];
      2'b01:   wave = edgeCnt[TAP_MID];
      2'b10:   wave = edgeCnt[TAP_HIGH];
      default: wave = edgeCnt[TAP_FAST];
    endcase
  end

  always_comb begin
    pinOe = strb.pinAllow && (strb.intMode || strb.oscRun);
    if (!pinOe) begin
      pinLevel = 1'b1;
    end else if (strb.intMode) begin
      pinLevel = !strb.irq;
    end else begin
      pinLevel = wave;
    end
  end

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.oscRun |=> $stable(edgeCnt));
  // R3
  cnt_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.oscRun && oscEdge |=> edgeCnt != $past(edgeCnt));
endmodule

// File: rtl/sqwIntCtrl.sv
module sqwIntCtrl
  import sqwPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscEdge,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [1:0]        alarmHit,
  input  logic              battMode,
  input  logic              oscFault,
  output logic              pinLevel,
  output logic              pinOe
);
  dpStrobes_t strb;

  sqwControl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .alarmHit(alarmHit),
    .battMode(battMode), .oscFault(oscFault), .strb(strb)
  );

  sqwDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .oscEdge(oscEdge), .strb(strb),
    .pinLevel(pinLevel), .pinOe(pinOe)
  );
endmodule

// File: tb/sqwIntCtrl_tb.sv
module sqwIntCtrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscEdge = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [1:0] alarmHit = 2'b00;
  logic       battMode = 1'b0;
  logic       oscFault = 1'b0;
  logic       pinLevel, pinOe;

  int checks = 0;
  int fails = 0;
  bit chkOn = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int edges = 0;
  bit [7:0] mCtrl = 8'h18;
  bit mOsf = 1'b1, mA1 = 1'b0, mA2 = 1'b0;
  bit wrC, wrS, stopEv;

  always #2.5 clk = ~clk;

  sqwIntCtrl u_dut (
    .clk(clk), .rstN(rstN), .oscEdge(oscEdge), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .alarmHit(alarmHit), .battMode(battMode), .oscFault(oscFault),
    .pinLevel(pinLevel), .pinOe(pinOe)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      edges = 0; mCtrl = 8'h18; mOsf = 1; mA1 = 0; mA2 = 0;
    end else begin
      wrC = regWrEn && regAddr == 8'h0E;
      wrS = regWrEn && regAddr == 8'h0F;
      stopEv = wrC && regWrData[7] && !mCtrl[7];
      if (!mCtrl[7] && oscEdge) edges = (edges + 1) % 65536;
      if (oscFault || stopEv) mOsf = 1;
      else if (wrS && !regWrData[7]) mOsf = 0;
      if (alarmHit[0]) mA1 = 1;
      else if (wrS && !regWrData[0]) mA1 = 0;
      if (alarmHit[1]) mA2 = 1;
      else if (wrS && !regWrData[1]) mA2 = 0;
      if (wrC) mCtrl = regWrData & 8'hBF;
    end
  end

  function automatic bit [7:0] expRd(bit [7:0] a);
    if (a == 8'h0E) return mCtrl;
    if (a == 8'h0F) return {mOsf, 5'b0, mA2, mA1};
    return 8'h00;
  endfunction

  function automatic bit expOe();
    return (!battMode || mCtrl[5]) && (mCtrl[2] || !mCtrl[7]);
  endfunction

  function automatic bit expLevel();
    int tap;
    if (!expOe()) return 1'b1;
    if (mCtrl[2]) return !((mA1 && mCtrl[0]) || (mA2 && mCtrl[1]));
    case (mCtrl[4:3])
      2'b00: tap = 15;
      2'b01: tap = 3;
      2'b10: tap = 2;
      default: tap = 0;
    endcase
    return ((edges >> tap) & 1) != 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn && !done) begin
      check(pinOe == expOe(), (battMode && !mCtrl[5]) ? "R8 oe" : "R4 oe", pinOe, expOe());
      check(pinLevel == expLevel(),
            !expOe() ? "R9 level" : (mCtrl[2] ? "R7 level" : "R3 level"),
            pinLevel, expLevel());
      check(regRdData == expRd(regAddr),
            regAddr == 8'h0F ? "R5/R6 status" : "R2 read", regRdData, expRd(regAddr));
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wrReg(bit [7:0] a, bit [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5ns * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    tick(4);
    rstN = 1;
    chkOn = 1;
    // R1 explicit reset state
    regAddr = 8'h0E; #1;
    check(regRdData == 8'h18, "R1 ctrl reset", regRdData, 8'h18);
    regAddr = 8'h0F; #1;
    check(regRdData == 8'h80, "R1 status reset", regRdData, 8'h80);
    check(pinOe == 1'b1 && pinLevel == 1'b0, "R1 pin reset", {pinOe, pinLevel}, 2'b10);
    oscEdge = 1;
    tick(100);
    // R3 each rate, steady and irregular edge patterns
    wrReg(8'h0E, 8'h08); tick(200);
    wrReg(8'h0E, 8'h10);
    for (int i = 0; i < 300; i++) begin oscEdge = (i % 3) != 0; tick(1); end
    oscEdge = 1;
    wrReg(8'h0E, 8'h18); tick(50);
    wrReg(8'h0E, 8'h40); regAddr = 8'h0E; tick(2);   // R2 bit6 reads 0
    regAddr = 8'h05; tick(2);                          // R2 other address
    wrReg(8'h0E, 8'h00); tick(70000);                  // R3 1 Hz
    // R5 flag handling
    regAddr = 8'h0F;
    wrReg(8'h0F, 8'h00); tick(3);
    wrReg(8'h0F, 8'h83); tick(3);
    oscFault = 1; tick(1); oscFault = 0; tick(3);
    wrReg(8'h0F, 8'h00);
    regWrEn = 1; regAddr = 8'h0F; regWrData = 8'h00; oscFault = 1; tick(1);
    regWrEn = 0; oscFault = 0; tick(3);
    wrReg(8'h0F, 8'h00);
    // R4 stop oscillator
    wrReg(8'h0E, 8'h98); regAddr = 8'h0F; tick(50);
    wrReg(8'h0F, 8'h00);
    wrReg(8'h0E, 8'h98); tick(5);                      // already stopped: no set
    wrReg(8'h0E, 8'h9C); tick(5);                      // stopped, interrupt mode
    wrReg(8'h0E, 8'h18); tick(40);
    // R6 / R7 alarms
    wrReg(8'h0E, 8'h04); regAddr = 8'h0F;
    alarmHit = 2'b01; tick(1); alarmHit = 0; tick(3);
    wrReg(8'h0E, 8'h05); regAddr = 8'h0F; tick(3);
    wrReg(8'h0F, 8'h01); tick(3);
    wrReg(8'h0F, 8'h02); tick(3);
    regWrEn = 1; regAddr = 8'h0F; regWrData = 8'h00; alarmHit = 2'b11; tick(1);
    regWrEn = 0; alarmHit = 0; tick(3);
    wrReg(8'h0F, 8'h02); tick(3);
    wrReg(8'h0E, 8'h06); regAddr = 8'h0F; tick(3);
    wrReg(8'h0F, 8'h00); tick(3);
    alarmHit = 2'b10; tick(1); alarmHit = 0; tick(3);
    wrReg(8'h0E, 8'h02); tick(20);                     // square wave despite flag
    // R8 battery mode
    battMode = 1; tick(10);
    wrReg(8'h0E, 8'h38); tick(30);
    wrReg(8'h0E, 8'h9C); tick(10);
    battMode = 0; wrReg(8'h0E, 8'h18); tick(20);
    finishRun();
  end
endmodule